// File: doc/BRIEF.md
# Iterative Gradient-Descent Estimate Updater

This block performs one gradient-descent refinement of a complex channel estimate held as a real-expanded matrix A of signed 8-bit coefficients, with ROWS rows (two per user) and COLS columns (one per chip). Each new coefficient is the old coefficient plus a step-scaled error term. The error is the cross-correlation entry minus the matching entry of the auto-correlation matrix times A. The step size is a power of two, so the scaling is an arithmetic right shift by MU bits that truncates toward minus infinity. The sum is clamped to the signed 8-bit range before it is stored.

The matrix product is spread over LANES signed 8-bit multipliers. LANES can be one, which gives the least area, or ROWS, which gives full parallelism in the inner dimension. The block walks its output elements in row-major order. For each element it drives a row index, a column index and an inner-dimension base index. The surrounding logic answers in the same cycle with LANES auto-correlation entries and one cross-correlation entry. The old coefficients and the new ones live in two separate buffers, and the buffers exchange roles when the iteration finishes. A single start pulse begins an iteration and a one-cycle done pulse ends it. To run a fixed number of iterations, the caller issues that many start pulses.

Top module: `est_grad_updater`

## Requirements
- R1: Each new coefficient A'[i][j] equals clamp(A[i][j] + floor((Rbr[i][j] - S) / 2^MU)), where S is the sum over k = 0..ROWS-1 of Rbb[i][k]*A[k][j]. The sum is taken at full precision, and the division is an arithmetic right shift by MU.
- R2: Results above 127 are stored as 127, and results below -128 are stored as -128.
- R3: Take the clock edge that accepts start as edge 0. done is high after edge ROWS*COLS*ROWS/LANES, and busy is high from edge 0 up to that edge.
- R4: After reset, busy and done are low and every coefficient in both buffers reads 0. done is high for exactly one cycle, and busy is low while done is high.
- R5: A start pulse received while busy is high has no effect: it neither restarts the iteration nor lengthens it.
- R6: rd_data returns A[rd_row][rd_col] from the current buffer without delay. During an iteration this is the old matrix. After done it is the new matrix.
- R7: A write through load_en stores into the current buffer only while busy is low. A load attempted while busy is high is dropped.
- R8: While busy, lane g of rbb_slice (bits 8g+7..8g) must carry Rbb[est_row][est_kbase+g], and rbr_elem must carry Rbr[est_row][est_col]. est_kbase is a multiple of LANES.
- R9: Every legal LANES value (a divisor of ROWS) gives bit-identical results.
- R10: A second start with no reload iterates on the matrix produced by the previous iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an iteration when the block is idle |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle pulse after the last coefficient is written |
| est_row | output | clog2(ROWS) | Row of the element being computed |
| est_col | output | clog2(COLS) | Column of the element being computed |
| est_kbase | output | clog2(ROWS) | First inner index of the current slice |
| rbb_slice | input | LANES*8 | Auto-correlation entries, lane g at bits 8g+7..8g |
| rbr_elem | input | 8 | Cross-correlation entry, signed |
| load_en | input | 1 | Coefficient write strobe |
| load_row | input | clog2(ROWS) | Write row |
| load_col | input | clog2(COLS) | Write column |
| load_data | input | 8 | Write value, signed |
| rd_row | input | clog2(ROWS) | Read row |
| rd_col | input | clog2(COLS) | Read column |
| rd_data | output | 8 | Coefficient from the current buffer, signed |

## Verification
The bench builds two copies with ROWS = COLS = 4 and MU = 2: one with LANES = 4 and one with LANES = 1. Both copies receive identical stimulus. The pair exposes the single-step accumulation path next to the multi-step one, and the 16-cycle latency next to the 64-cycle latency. Their results must agree with each other and with an integer model. Directed matrices drive the clamp at both ends and exercise negative truncation. Seeded random matrices and a chained second iteration exercise the full product. In the middle of one iteration the bench asserts start, asserts load and reads a coefficient, to test that each of these is handled as the requirements state.

// File: rtl/est_pkg.sv
`timescale 1ns/1ps
package est_pkg;
    localparam int DW = 8;

    typedef logic signed [DW-1:0] coef_t;

    // clamp a wide signed value into the coefficient range
    function automatic coef_t clamp_coef(input logic signed [31:0] v);
        if (v > 32'sd127) begin
            return 8'sd127;
        end else if (v < -32'sd128) begin
            return -8'sd128;
        end
        return v[DW-1:0];
    endfunction
endpackage

// File: rtl/est_mac_array.sv
`timescale 1ns/1ps
module est_mac_array
    import est_pkg::*;
#(
    parameter int LANES = 2,
    parameter int SUM_W = 2*DW + $clog2(LANES) + 1
) (
    input  logic [LANES*DW-1:0]     rbb_lanes,
    input  logic [LANES*DW-1:0]     a_lanes,
    output logic signed [SUM_W-1:0] partial
);
    localparam int PROD_W = 2*DW;

    logic signed [PROD_W-1:0] prod [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign prod[g] = PROD_W'($signed(rbb_lanes[g*DW +: DW]))
                       * PROD_W'($signed(a_lanes[g*DW +: DW]));
    end

    always_comb begin
        partial = '0;
        for (int g = 0; g < LANES; g++) begin
            partial = partial + SUM_W'(prod[g]);
        end
    end
endmodule

// File: rtl/est_coef_bank.sv
`timescale 1ns/1ps
module est_coef_bank
    import est_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LANES = 2,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                swap,
    input  logic                ld_en,
    input  logic [RW-1:0]       ld_row,
    input  logic [CW-1:0]       ld_col,
    input  coef_t               ld_data,
    input  logic                up_en,
    input  logic [RW-1:0]       up_row,
    input  logic [CW-1:0]       up_col,
    input  coef_t               up_data,
    input  logic [CW-1:0]       tap_col,
    input  logic [RW-1:0]       tap_kbase,
    output logic [LANES*DW-1:0] tap_data,
    input  logic [RW-1:0]       cur_row,
    input  logic [CW-1:0]       cur_col,
    output coef_t               cur_data,
    input  logic [RW-1:0]       rd_row,
    input  logic [CW-1:0]       rd_col,
    output coef_t               rd_data
);
    localparam int DEPTH = ROWS * COLS;

    coef_t mem_q [2][DEPTH];
    logic  sel_q, sel_d;

    function automatic int flat(input int r, input int c);
        return r * COLS + c;
    endfunction

    always_comb begin
        sel_d = swap ? ~sel_q : sel_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            for (int b = 0; b < 2; b++) begin
                for (int e = 0; e < DEPTH; e++) begin
                    mem_q[b][e] <= '0;
                end
            end
        end else begin
            sel_q <= sel_d;
            if (ld_en) begin
                mem_q[sel_q][flat(int'(ld_row), int'(ld_col))] <= ld_data;
            end
            if (up_en) begin
                mem_q[~sel_q][flat(int'(up_row), int'(up_col))] <= up_data;
            end
        end
    end

    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            tap_data[g*DW +: DW] = mem_q[sel_q][flat(int'(tap_kbase) + g, int'(tap_col))];
        end
        cur_data = mem_q[sel_q][flat(int'(cur_row), int'(cur_col))];
        rd_data  = mem_q[sel_q][flat(int'(rd_row), int'(rd_col))];
    end

    // R7: a software load never coincides with an iteration write-back
    p_no_load_in_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |-> !ld_en);
endmodule

// File: rtl/est_update_stage.sv
`timescale 1ns/1ps
module est_update_stage
    import est_pkg::*;
#(
    parameter int ACC_W = 19,
    parameter int MU    = 2
) (
    input  coef_t                   a_old,
    input  coef_t                   rbr,
    input  logic signed [ACC_W-1:0] acc,
    output coef_t                   a_new
);
    localparam int XW = ACC_W + 2;

    logic signed [XW-1:0] diff, scaled, total;

    always_comb begin
        diff   = XW'(rbr) - XW'(acc);
        scaled = diff >>> MU;
        total  = scaled + XW'(a_old);
        a_new  = clamp_coef(32'(total));
    end
endmodule

// File: rtl/est_grad_updater.sv
`timescale 1ns/1ps
module est_grad_updater
    import est_pkg::*;
#(
    parameter int ROWS  = 4,
    parameter int COLS  = 4,
    parameter int LANES = 2,
    parameter int MU    = 2,
    localparam int RW   = $clog2(ROWS),
    localparam int CW   = $clog2(COLS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic                busy,
    output logic                done,
    output logic [RW-1:0]       est_row,
    output logic [CW-1:0]       est_col,
    output logic [RW-1:0]       est_kbase,
    input  logic [LANES*DW-1:0] rbb_slice,
    input  logic signed [DW-1:0] rbr_elem,
    input  logic                load_en,
    input  logic [RW-1:0]       load_row,
    input  logic [CW-1:0]       load_col,
    input  logic signed [DW-1:0] load_data,
    input  logic [RW-1:0]       rd_row,
    input  logic [CW-1:0]       rd_col,
    output logic signed [DW-1:0] rd_data
);
    localparam int STEPS = ROWS / LANES;
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int SUM_W = 2*DW + $clog2(LANES) + 1;
    localparam int ACC_W = 2*DW + $clog2(ROWS) + 1;

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic [RW-1:0]           row;
        logic [CW-1:0]           col;
        logic [SW-1:0]           step;
        logic signed [ACC_W-1:0] acc;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [LANES*DW-1:0]     a_taps;
    logic signed [SUM_W-1:0] partial;
    logic signed [ACC_W-1:0] acc_total;
    coef_t                   a_cur, a_next, rd_coef;
    logic                    wr_back, swap_bufs, ld_ok;

    assign busy      = ctl_q.busy;
    assign done      = ctl_q.done;
    assign est_row   = ctl_q.row;
    assign est_col   = ctl_q.col;
    assign est_kbase = RW'(int'(ctl_q.step) * LANES);
    assign ld_ok     = load_en && !ctl_q.busy;
    assign rd_data   = rd_coef;
    assign acc_total = ctl_q.acc + ACC_W'(partial);

    est_coef_bank #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (swap_bufs),
        .ld_en     (ld_ok),
        .ld_row    (load_row),
        .ld_col    (load_col),
        .ld_data   (load_data),
        .up_en     (wr_back),
        .up_row    (ctl_q.row),
        .up_col    (ctl_q.col),
        .up_data   (a_next),
        .tap_col   (ctl_q.col),
        .tap_kbase (est_kbase),
        .tap_data  (a_taps),
        .cur_row   (ctl_q.row),
        .cur_col   (ctl_q.col),
        .cur_data  (a_cur),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .rd_data   (rd_coef)
    );

    est_mac_array #(.LANES(LANES), .SUM_W(SUM_W)) u_mac (
        .rbb_lanes (rbb_slice),
        .a_lanes   (a_taps),
        .partial   (partial)
    );

    est_update_stage #(.ACC_W(ACC_W), .MU(MU)) u_upd (
        .a_old (a_cur),
        .rbr   (rbr_elem),
        .acc   (acc_total),
        .a_new (a_next)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        wr_back    = 1'b0;
        swap_bufs  = 1'b0;
        if (!ctl_q.busy) begin
            if (start) begin
                ctl_d.busy = 1'b1;
                ctl_d.row  = '0;
                ctl_d.col  = '0;
                ctl_d.step = '0;
                ctl_d.acc  = '0;
            end
        end else if (ctl_q.step == SW'(STEPS - 1)) begin
            wr_back    = 1'b1;
            ctl_d.step = '0;
            ctl_d.acc  = '0;
            if (ctl_q.col == CW'(COLS - 1)) begin
                ctl_d.col = '0;
                if (ctl_q.row == RW'(ROWS - 1)) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    swap_bufs  = 1'b1;
                end else begin
                    ctl_d.row = ctl_q.row + 1'b1;
                end
            end else begin
                ctl_d.col = ctl_q.col + 1'b1;
            end
        end else begin
            ctl_d.step = ctl_q.step + 1'b1;
            ctl_d.acc  = acc_total;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R4: done lasts one cycle and never overlaps busy
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R3: an iteration only ends through done
    p_busy_ends_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R5: an iteration only begins from idle with start
    p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/est_grad_updater_tb.sv
`timescale 1ns/1ps
module est_grad_updater_tb;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int MU   = 2;
    localparam int PA   = 4;
    localparam int PB   = 1;
    localparam int LAT_A = ROWS * COLS * ROWS / PA;
    localparam int LAT_B = ROWS * COLS * ROWS / PB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic load_en = 1'b0;
    logic [1:0] load_row = '0, load_col = '0, rd_row = '0, rd_col = '0;
    logic signed [7:0] load_data = '0;

    logic busy_a, done_a, busy_b, done_b;
    logic [1:0] row_a, col_a, kb_a, row_b, col_b, kb_b;
    logic [PA*8-1:0] sl_a;
    logic [PB*8-1:0] sl_b;
    logic signed [7:0] rbr_a, rbr_b, rd_a, rd_b;

    int rbb [ROWS][ROWS];
    int rbr [ROWS][COLS];
    int a_mod [ROWS][COLS];
    int a_exp [ROWS][COLS];
    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    est_grad_updater #(.ROWS(ROWS), .COLS(COLS), .LANES(PA), .MU(MU)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_a), .done(done_a),
        .est_row(row_a), .est_col(col_a), .est_kbase(kb_a),
        .rbb_slice(sl_a), .rbr_elem(rbr_a),
        .load_en(load_en), .load_row(load_row), .load_col(load_col), .load_data(load_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_a));

    est_grad_updater #(.ROWS(ROWS), .COLS(COLS), .LANES(PB), .MU(MU)) u_dut_p1 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy_b), .done(done_b),
        .est_row(row_b), .est_col(col_b), .est_kbase(kb_b),
        .rbb_slice(sl_b), .rbr_elem(rbr_b),
        .load_en(load_en), .load_row(load_row), .load_col(load_col), .load_data(load_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_b));

    // R8: correlation data served from the addresses the block drives
    always_comb begin
        for (int g = 0; g < PA; g++) begin
            sl_a[g*8 +: 8] = 8'(rbb[row_a][(int'(kb_a) + g) % ROWS]);
        end
        for (int g = 0; g < PB; g++) begin
            sl_b[g*8 +: 8] = 8'(rbb[row_b][(int'(kb_b) + g) % ROWS]);
        end
        rbr_a = 8'(rbr[row_a][col_a]);
        rbr_b = 8'(rbr[row_b][col_b]);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clamp8(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic model_step();
        for (int i = 0; i < ROWS; i++) begin
            for (int j = 0; j < COLS; j++) begin
                int acc = 0;
                int d;
                for (int k = 0; k < ROWS; k++) acc += rbb[i][k] * a_mod[k][j];
                d = rbr[i][j] - acc;
                a_exp[i][j] = clamp8(a_mod[i][j] + (d >>> MU));
            end
        end
    endtask

    task automatic load_all();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                load_en = 1'b1; load_row = 2'(r); load_col = 2'(c);
                load_data = 8'(a_mod[r][c]);
            end
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic verify_all(input string tag);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                rd_row = 2'(r); rd_col = 2'(c);
                #1;
                check(int'(rd_a) == a_exp[r][c], {tag, " R1 R8 lanes=4"}, int'(rd_a), a_exp[r][c]);
                check(int'(rd_b) == a_exp[r][c], {tag, " R9 lanes=1"}, int'(rd_b), a_exp[r][c]);
            end
        end
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) a_mod[r][c] = a_exp[r][c];
    endtask

    task automatic run_iter(input bit poke);
        int first_a = -1, first_b = -1, n_da = 0, n_db = 0;
        model_step();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int cnt = 1; cnt <= LAT_B + 6; cnt++) begin
            @(negedge clk);
            if (poke && cnt == 3) begin
                start = 1'b1; load_en = 1'b1; load_row = 2'd0; load_col = 2'd0;
                load_data = 8'sd55; rd_row = 2'd0; rd_col = 2'd0;
                #1;
                check(int'(rd_a) == a_mod[0][0], "R6 old buffer lanes=4", int'(rd_a), a_mod[0][0]);
                check(int'(rd_b) == a_mod[0][0], "R6 old buffer lanes=1", int'(rd_b), a_mod[0][0]);
                check(busy_a == 1'b1, "R3 busy during run", int'(busy_a), 1);
            end
            if (poke && cnt == 4) begin
                start = 1'b0; load_en = 1'b0;
            end
            if (done_a) begin
                if (first_a < 0) first_a = cnt;
                n_da++;
                check(busy_a == 1'b0, "R4 busy low with done", int'(busy_a), 0);
            end
            if (done_b) begin
                if (first_b < 0) first_b = cnt;
                n_db++;
            end
        end
        check(first_a == LAT_A, "R3 R5 latency lanes=4", first_a, LAT_A);
        check(first_b == LAT_B, "R3 R5 latency lanes=1", first_b, LAT_B);
        check(n_da == 1, "R4 done pulses lanes=4", n_da, 1);
        check(n_db == 1, "R4 done pulses lanes=1", n_db, 1);
        if (poke) begin
            @(negedge clk);
            rd_row = 2'd0; rd_col = 2'd0;
            #1;
            check(int'(rd_a) == a_exp[0][0], "R7 busy load dropped", int'(rd_a), a_exp[0][0]);
        end
    endtask

    task automatic fill(input int a_v, input int rbb_v, input int rbr_v, input bit rnd);
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                a_mod[r][c] = rnd ? (int'($urandom_range(255)) - 128) : a_v;
                rbr[r][c]   = rnd ? (int'($urandom_range(255)) - 128) : rbr_v;
            end
            for (int k = 0; k < ROWS; k++)
                rbb[r][k] = rnd ? (int'($urandom_range(255)) - 128) : rbb_v;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd7321);
        fill(0, 0, 0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_a == 1'b0 && busy_b == 1'b0, "R4 reset busy", int'(busy_a), 0);
        check(done_a == 1'b0 && done_b == 1'b0, "R4 reset done", int'(done_a), 0);
        rd_row = 2'd3; rd_col = 2'd2;
        #1;
        check(rd_a == 8'sd0 && rd_b == 8'sd0, "R4 reset coefficients", int'(rd_a), 0);

        // R1: truncation toward minus infinity with zero correlation
        fill(0, 0, 0, 1'b0);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) rbr[r][c] = (r * COLS + c) * 3 - 23;
        load_all();
        run_iter(1'b0);
        verify_all("R1 truncation");

        // R2: upper clamp
        fill(127, 0, 127, 1'b0);
        load_all();
        run_iter(1'b0);
        verify_all("R2 clamp high");

        // R2: lower clamp
        fill(-128, 0, -128, 1'b0);
        load_all();
        run_iter(1'b0);
        verify_all("R2 clamp low");

        // random matrices, one with mid-run start, load and read
        for (int t = 0; t < 4; t++) begin
            fill(0, 0, 0, 1'b1);
            for (int r = 0; r < ROWS; r++)
                for (int k = 0; k < ROWS; k++) rbb[r][k] = rbb[r][k] / 16;
            load_all();
            run_iter(t == 1);
            verify_all("R1 random");
            // R10: chained iteration on the result just produced
            run_iter(1'b0);
            verify_all("R10 chained");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule